// File: doc/BRIEF.md
# NaN Payload Format Converter

This block takes a NaN held in one IEEE binary interchange width (half, single or double) and re-encodes it in another. The source fraction is first left-aligned into a 64-bit canonical payload word, with the sign kept beside it. The destination then takes as many of the top canonical bits as its own fraction holds. The sign is kept, and the exponent is driven to all ones. When the narrowed payload comes out as zero, or when the caller asks for default-NaN behaviour, the block emits a fixed default NaN pattern for the destination width instead.

The block also reports an invalid-operation flag when the incoming operand is a signaling NaN. The conversion logic is combinational. Its result is registered once and qualified by a valid strobe, so a request presented in one cycle is answered on the next. Classifying ordinary numbers and doing any arithmetic are left to the surrounding datapath.

Top module: `nan_fmt_convert`

## Requirements
- R1: Results appear exactly one clock after the request: `out_valid` is high in the cycle after `in_valid` was sampled high and low after a cycle with `in_valid` low. Reset clears `out_valid`, `out_val` and `invalid` to zero.
- R2: Format codes are 0 = half (16 bits), 1 = single (32 bits), 2 = double (64 bits), and code 3 behaves as double. The source sits right-aligned in `src_val` and bits above its width are ignored. Bits of `out_val` above the destination width are zero.
- R3: The source fraction is left-aligned into a 64-bit canonical word, with half shifted by 54, single by 41 and double by 12. The destination fraction is the top 10, 23 or 52 canonical bits. The output is {source sign, all-ones exponent, that fraction}, and the quiet bit is not forced.
- R4: If the destination fraction extracted under R3 is zero, the output is the destination default NaN.
- R5: When `dnan_mode` is high, the output is the destination default NaN whatever the source payload.
- R6: `invalid` is high together with `out_valid` exactly when the sampled source was a signaling NaN, meaning all-ones exponent, fraction MSB zero and remaining fraction bits nonzero. This holds in default-NaN mode too, and the flag lasts one cycle per request.
- R7: With `ALT_DNAN`=0 the default NaNs are 0xFE00, 0xFFC00000 and 0xFFF8000000000000. With `ALT_DNAN`=1 they are 0x7E00, 0x7FC00000 and 0x7FF8000000000000.
- R8: A cycle with `in_valid` low leaves `out_val` unchanged and `invalid` low, even if a signaling NaN is present on `src_val`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| src_fmt | input | 2 | Source format code |
| dst_fmt | input | 2 | Destination format code |
| dnan_mode | input | 1 | Force destination default NaN |
| src_val | input | 64 | Source NaN, right-aligned |
| out_valid | output | 1 | Result strobe, one cycle after request |
| out_val | output | 64 | Converted NaN, right-aligned, upper bits zero |
| invalid | output | 1 | Source was a signaling NaN |

## Verification
The bench builds two copies side by side, one with `ALT_DNAN`=0 and one with `ALT_DNAN`=1, and feeds both the same requests. Every case that falls back to a default NaN therefore shows both pattern sets, including the difference in the sign bit. Payload-carrying cases must agree between the two copies, which separates a truncation-to-zero fallback from true payload transfer.

// File: rtl/nan_cvt_pkg.sv
package nan_cvt_pkg;
  localparam int CANON_W = 64;

  typedef enum logic [1:0] {
    FMT_HALF   = 2'd0,
    FMT_SINGLE = 2'd1,
    FMT_DOUBLE = 2'd2,
    FMT_RSVD   = 2'd3
  } nan_fmt_e;

  localparam int HALF_FW   = 10;
  localparam int SINGLE_FW = 23;
  localparam int DOUBLE_FW = 52;
  localparam int HALF_SH   = CANON_W - HALF_FW;
  localparam int SINGLE_SH = CANON_W - SINGLE_FW;
  localparam int DOUBLE_SH = CANON_W - DOUBLE_FW;
endpackage

// File: rtl/nan_unpack.sv
module nan_unpack
  import nan_cvt_pkg::*;
(
  input  nan_fmt_e             fmt,
  input  logic [CANON_W-1:0]   src,
  output logic                 sign,
  output logic [CANON_W-1:0]   canon,
  output logic                 is_snan
);
  logic exp_ones;
  logic qbit;
  logic rest_nz;

  always_comb begin
    case (fmt)
      FMT_HALF: begin
        sign     = src[15];
        canon    = {src[HALF_FW-1:0], {HALF_SH{1'b0}}};
        exp_ones = &src[14:10];
        qbit     = src[9];
        rest_nz  = |src[8:0];
      end
      FMT_SINGLE: begin
        sign     = src[31];
        canon    = {src[SINGLE_FW-1:0], {SINGLE_SH{1'b0}}};
        exp_ones = &src[30:23];
        qbit     = src[22];
        rest_nz  = |src[21:0];
      end
      default: begin
        sign     = src[63];
        canon    = {src[DOUBLE_FW-1:0], {DOUBLE_SH{1'b0}}};
        exp_ones = &src[62:52];
        qbit     = src[51];
        rest_nz  = |src[50:0];
      end
    endcase
    is_snan = exp_ones & ~qbit & rest_nz;
  end
endmodule

// File: rtl/nan_pack.sv
module nan_pack
  import nan_cvt_pkg::*;
#(
  parameter bit ALT_DNAN = 1'b0
)(
  input  nan_fmt_e             fmt,
  input  logic                 sign,
  input  logic [CANON_W-1:0]   canon,
  input  logic                 dnan_mode,
  output logic [CANON_W-1:0]   val
);
  logic [CANON_W-1:0] dflt_h, dflt_s, dflt_d;

  generate
    if (ALT_DNAN) begin : g_pos_dflt
      assign dflt_h = 64'h0000_0000_0000_7E00;
      assign dflt_s = 64'h0000_0000_7FC0_0000;
      assign dflt_d = 64'h7FF8_0000_0000_0000;
    end else begin : g_neg_dflt
      assign dflt_h = 64'h0000_0000_0000_FE00;
      assign dflt_s = 64'h0000_0000_FFC0_0000;
      assign dflt_d = 64'hFFF8_0000_0000_0000;
    end
  endgenerate

  logic [HALF_FW-1:0]   pay_h;
  logic [SINGLE_FW-1:0] pay_s;
  logic [DOUBLE_FW-1:0] pay_d;
  logic                 unused_low;

  assign pay_h      = canon[CANON_W-1 -: HALF_FW];
  assign pay_s      = canon[CANON_W-1 -: SINGLE_FW];
  assign pay_d      = canon[CANON_W-1 -: DOUBLE_FW];
  assign unused_low = ^canon[DOUBLE_SH-1:0];

  always_comb begin
    case (fmt)
      FMT_HALF: begin
        if (dnan_mode || (pay_h == '0)) val = dflt_h;
        else val = {48'b0, sign, 5'h1F, pay_h};
      end
      FMT_SINGLE: begin
        if (dnan_mode || (pay_s == '0)) val = dflt_s;
        else val = {32'b0, sign, 8'hFF, pay_s};
      end
      default: begin
        if (dnan_mode || (pay_d == '0)) val = dflt_d;
        else val = {sign, 11'h7FF, pay_d};
      end
    endcase
  end
endmodule

// File: rtl/nan_fmt_convert.sv
module nan_fmt_convert
  import nan_cvt_pkg::*;
#(
  parameter bit ALT_DNAN = 1'b0
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [1:0]  src_fmt,
  input  logic [1:0]  dst_fmt,
  input  logic        dnan_mode,
  input  logic [63:0] src_val,
  output logic        out_valid,
  output logic [63:0] out_val,
  output logic        invalid
);
  logic               c_sign;
  logic [CANON_W-1:0] c_word;
  logic               c_snan;
  logic [CANON_W-1:0] conv_val;

  nan_unpack u_unpack (
    .fmt     (nan_fmt_e'(src_fmt)),
    .src     (src_val),
    .sign    (c_sign),
    .canon   (c_word),
    .is_snan (c_snan)
  );

  nan_pack #(.ALT_DNAN(ALT_DNAN)) u_pack (
    .fmt       (nan_fmt_e'(dst_fmt)),
    .sign      (c_sign),
    .canon     (c_word),
    .dnan_mode (dnan_mode),
    .val       (conv_val)
  );

  logic        vld_d, inv_d;
  logic [63:0] val_d;

  always_comb begin
    vld_d = in_valid;
    inv_d = in_valid & c_snan;
    val_d = in_valid ? conv_val : out_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      invalid   <= 1'b0;
      out_val   <= '0;
    end else begin
      out_valid <= vld_d;
      invalid   <= inv_d;
      out_val   <= val_d;
    end
  end

  logic exp_ok;
  logic upper_ok;
  always_comb begin
    case (dst_fmt)
      2'd0:    begin exp_ok = &conv_val[14:10]; upper_ok = (conv_val[63:16] == '0); end
      2'd1:    begin exp_ok = &conv_val[30:23]; upper_ok = (conv_val[63:32] == '0); end
      default: begin exp_ok = &conv_val[62:52]; upper_ok = 1'b1; end
    endcase
  end

  a_r1_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r6_invalid_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    invalid |-> out_valid);
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_val) && !invalid));
  a_r3_exp_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> exp_ok);
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> upper_ok);
endmodule

// File: tb/nan_fmt_convert_bench.sv
`timescale 1ns/1ps
module nan_fmt_convert_bench;
  localparam real CLK_P = 8.0;
  localparam int  NV    = 13;
  localparam int  VW    = 202;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  src_fmt, dst_fmt;
  logic        dnan_mode;
  logic [63:0] src_val;
  logic        ov0, ov1, inv0, inv1;
  logic [63:0] val0, val1;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  nan_fmt_convert #(.ALT_DNAN(1'b0)) u_nan_fmt_convert (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_fmt(src_fmt),
    .dst_fmt(dst_fmt), .dnan_mode(dnan_mode), .src_val(src_val),
    .out_valid(ov0), .out_val(val0), .invalid(inv0));

  nan_fmt_convert #(.ALT_DNAN(1'b1)) u_alt (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_fmt(src_fmt),
    .dst_fmt(dst_fmt), .dnan_mode(dnan_mode), .src_val(src_val),
    .out_valid(ov1), .out_val(val1), .invalid(inv1));

  // {src_fmt, dst_fmt, dnan, src, expected ALT0, expected ALT1, invalid, req}
  localparam logic [VW-1:0] VEC [NV] = '{
    {2'd0, 2'd0, 1'b0, 64'h7E01, 64'h7E01, 64'h7E01, 1'b0, 4'd3},                         // R3 half->half
    {2'd0, 2'd0, 1'b0, 64'hFC01, 64'hFC01, 64'hFC01, 1'b1, 4'd3},                         // R3 sNaN kept unquieted
    {2'd1, 2'd2, 1'b0, 64'h7FC00001, 64'h7FF8000020000000, 64'h7FF8000020000000, 1'b0, 4'd3}, // R3 widen
    {2'd2, 2'd1, 1'b0, 64'hFFF0000000000001, 64'hFFC00000, 64'h7FC00000, 1'b1, 4'd4},     // R4 payload lost
    {2'd2, 2'd0, 1'b0, 64'h7FF4000000000000, 64'h7D00, 64'h7D00, 1'b1, 4'd3},             // R3 narrow
    {2'd1, 2'd0, 1'b0, 64'hFFA00000, 64'hFD00, 64'hFD00, 1'b1, 4'd3},                     // R3 sign kept
    {2'd0, 2'd1, 1'b1, 64'h7E00, 64'hFFC00000, 64'h7FC00000, 1'b0, 4'd5},                 // R5
    {2'd1, 2'd2, 1'b1, 64'h7F800001, 64'hFFF8000000000000, 64'h7FF8000000000000, 1'b1, 4'd5}, // R5 + R6
    {2'd3, 2'd3, 1'b0, 64'h7FF8000000000123, 64'h7FF8000000000123, 64'h7FF8000000000123, 1'b0, 4'd2}, // R2 code 3
    {2'd0, 2'd0, 1'b0, 64'hDEADBEEF00007E05, 64'h7E05, 64'h7E05, 1'b0, 4'd2},             // R2 junk ignored
    {2'd0, 2'd2, 1'b0, 64'hFE00, 64'hFFF8000000000000, 64'hFFF8000000000000, 1'b0, 4'd3}, // R3 payload path
    {2'd1, 2'd0, 1'b0, 64'h7F800001, 64'hFE00, 64'h7E00, 1'b1, 4'd4},                     // R4 R7
    {2'd2, 2'd2, 1'b1, 64'h7FF0000000000001, 64'hFFF8000000000000, 64'h7FF8000000000000, 1'b1, 4'd7} // R7
  };

  task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check1(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    rst_n = 1'b0; in_valid = 1'b0; src_fmt = '0; dst_fmt = '0;
    dnan_mode = 1'b0; src_val = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check1("R1 reset out_valid", ov0, 1'b0);
    check1("R1 reset invalid", inv0, 1'b0);
    check64("R1 reset out_val", val0, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      src_fmt   = v[201:200];
      dst_fmt   = v[199:198];
      dnan_mode = v[197];
      src_val   = v[196:133];
      in_valid  = 1'b1;
      @(negedge clk);
      check1($sformatf("R1 vec %0d out_valid", i), ov0, 1'b1);
      check64($sformatf("R%0d vec %0d ALT0", v[3:0], i), val0, v[132:69]);
      check64($sformatf("R%0d vec %0d ALT1", v[3:0], i), val1, v[68:5]);
      check1($sformatf("R6 vec %0d invalid", i), inv0, v[4]);
      check1($sformatf("R6 vec %0d invalid alt", i), inv1, v[4]);
    end

    // R1/R6: idle cycle drops strobe and flag after a signaling request
    in_valid = 1'b0;
    held = val0;
    src_fmt = 2'd1; dst_fmt = 2'd1; dnan_mode = 1'b0; src_val = 64'h7F800001;
    @(negedge clk);
    check1("R1 idle out_valid", ov0, 1'b0);
    check1("R6 flag single cycle", inv0, 1'b0);
    // R8: signaling NaN presented while idle changes nothing
    check64("R8 value held", val0, held);
    @(negedge clk);
    check64("R8 value still held", val0, held);
    check1("R8 no invalid when idle", inv0, 1'b0);

    // R6: quiet source gives no flag
    src_fmt = 2'd1; dst_fmt = 2'd1; src_val = 64'hFFC00005; in_valid = 1'b1;
    @(negedge clk);
    check1("R6 quiet no flag", inv0, 1'b0);
    check64("R3 single->single", val0, 64'hFFC00005);
    in_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule